// File: doc/BRIEF.md
# Float-to-Logarithm Converter

This block turns a normalised 32-bit binary floating-point word into a fixed-point base-2 logarithm with the same 23-bit fractional precision. The integer part of the result is the unbiased exponent. The fractional part approximates log2(1+m), where m is the mantissa fraction. It is formed in two steps. First, a straight-line interpolation is taken inside one of 64 equal mantissa segments. Second, a correction is added: one shared, normalised error curve is scaled by a per-segment factor.

The shared curve is symmetric about the middle of a segment. Only its first half is stored. The upper half of the offset range reaches the same entries by XOR-inverting the table address. The datapath is a plain streaming pipeline with a valid strobe on each side and no back-pressure. A new word can enter on every clock.

Inputs that cannot be converted are flagged rather than converted. These are negative values, zeros, subnormals, infinities and NaNs. The base depth is two register stages. A parameter adds further delay stages, so a deeper option can be built for faster clocks.

Top module: `fl2log_conv`

## Requirements
- R1: For an accepted input, with bit 31 the sign, bits 30:23 the exponent field E and bits 22:0 the mantissa fraction, output bits 30:23 hold E-127 as an 8-bit two's-complement integer.
- R2: Output bits 22:0 hold the fraction of log2(1+m). The whole 31-bit output, read as a signed value scaled by 2^-23, stays within 4*2^-23 of log2 of the input.
- R3: An input whose mantissa field is zero produces a zero fraction exactly, so the output equals (E-127)*2^23.
- R4: The accuracy bound of R2 holds in both halves of every one of the 64 segments, including offsets a quarter, a half and three quarters into a segment and the last offset before the next segment.
- R5: An input with sign 1, or an exponent field of 0 or 255, produces out_err = 1 with out_log = 0 in its result cycle.
- R6: out_valid rises exactly 2 + EXTRA_STAGES rising edges after in_valid is sampled high. Results leave in input order, with one result per accepted word and none otherwise, including under back-to-back input and input with gaps.
- R7: While rst is high, and on the first cycle after, out_valid, out_err and out_log are all zero.
- R8: When rejected and accepted words alternate on consecutive cycles, each result carries only its own word's flag and value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_word | input | 32 | Floating-point input: sign bit 31, exponent 30:23, fraction 22:0 |
| out_valid | output | 1 | Result present this cycle |
| out_err | output | 1 | Result belongs to a rejected input |
| out_log | output | 31 | Logarithm: signed integer 30:23, fraction 22:0 |

## Verification
Two functions can fall in the same cycle. The rejection path forces a result to zero and raises the flag, while the conversion path finishes the previous word in the next stage. A fault in either can leak into the other. This is provoked by streaming rejected words (zeros, subnormals, negatives, infinities, NaNs) alternately with valid words, with no idle cycles between them. Each result is judged on its own against a real-valued log2 of its own input word, and its flag must match that word's class, in the order the words were sent.

// File: rtl/fl2log_pkg.sv
package fl2log_pkg;

    localparam int FP_W     = 32;
    localparam int EXP_W    = 8;
    localparam int MANT_W   = 23;
    localparam int EXP_BIAS = 127;
    localparam int GUARD_W  = 7;                  // extra fraction bits kept inside
    localparam int ACC_FRAC = MANT_W + GUARD_W;   // internal fraction width
    localparam int CURVE_W  = 16;                 // normalised curve sample width

    // log2(x) for x in [1,2], x given with ACC_FRAC fraction bits,
    // result is the fraction of the log with ACC_FRAC bits (elaboration only).
    function automatic longint unsigned log2_fix(input longint unsigned x);
        longint unsigned v;
        longint unsigned r;
        v = x;
        r = 64'd0;
        if (v >= (64'd1 << (ACC_FRAC + 1))) begin
            return 64'd1 << ACC_FRAC;
        end
        for (int b = ACC_FRAC - 1; b >= 0; b--) begin
            v = (v * v) >> ACC_FRAC;
            if (v >= (64'd1 << (ACC_FRAC + 1))) begin
                r = r | (64'd1 << b);
                v = v >> 1;
            end
        end
        return r;
    endfunction

    // Normalised chord-error curve 4u(1-u), sampled at bin centres.
    function automatic longint unsigned curve_entry(input longint unsigned idx,
                                                    input longint unsigned addr_w);
        longint unsigned k;
        longint unsigned n;
        k = 2 * idx + 1;
        n = 64'd1 << (addr_w + 1);
        return (4 * k * (n - k) * ((64'd1 << CURVE_W) - 1)) / (n * n);
    endfunction

endpackage

// File: rtl/fl2log_classify.sv
module fl2log_classify import fl2log_pkg::*; #(
    parameter int SEG_BITS = 6,
    parameter int OFF_W    = MANT_W - SEG_BITS
) (
    input  logic [FP_W-1:0]     word,
    output logic                bad,
    output logic [EXP_W-1:0]    ipart,
    output logic [SEG_BITS-1:0] seg,
    output logic [OFF_W-1:0]    off
);

    logic [EXP_W-1:0] exp_f;

    always_comb begin
        exp_f = word[FP_W-2 -: EXP_W];
        bad   = word[FP_W-1] | (exp_f == '0) | (exp_f == '1);
        ipart = exp_f - EXP_W'(EXP_BIAS);
        seg   = word[MANT_W-1 -: SEG_BITS];
        off   = word[OFF_W-1:0];
    end

endmodule

// File: rtl/fl2log_seg_rom.sv
module fl2log_seg_rom import fl2log_pkg::*; #(
    parameter int SEG_BITS = 6,
    parameter int SLOPE_W  = ACC_FRAC - SEG_BITS + 1,
    parameter int SCALE_W  = ACC_FRAC - 2 * SEG_BITS
) (
    input  logic [SEG_BITS-1:0] seg,
    output logic [ACC_FRAC-1:0] base,
    output logic [SLOPE_W-1:0]  slope,
    output logic [SCALE_W-1:0]  scale
);

    localparam int NSEG = 1 << SEG_BITS;
    localparam longint unsigned ONE = 64'd1 << ACC_FRAC;

    logic [ACC_FRAC-1:0] base_tab  [NSEG];
    logic [SLOPE_W-1:0]  slope_tab [NSEG];
    logic [SCALE_W-1:0]  scale_tab [NSEG];

    // per segment: left end, rise across the segment, chord error at mid-point
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam longint unsigned Y_LO  = log2_fix(ONE + (64'(s) << (ACC_FRAC - SEG_BITS)));
        localparam longint unsigned Y_HI  = log2_fix(ONE + (64'(s + 1) << (ACC_FRAC - SEG_BITS)));
        localparam longint unsigned Y_MID = log2_fix(ONE + (64'(2 * s + 1) << (ACC_FRAC - SEG_BITS - 1)));
        assign base_tab[s]  = ACC_FRAC'(Y_LO);
        assign slope_tab[s] = SLOPE_W'(Y_HI - Y_LO);
        assign scale_tab[s] = SCALE_W'(Y_MID - (Y_LO + Y_HI) / 2);
    end

    assign base  = base_tab[seg];
    assign slope = slope_tab[seg];
    assign scale = scale_tab[seg];

endmodule

// File: rtl/fl2log_curve_rom.sv
module fl2log_curve_rom import fl2log_pkg::*; #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [CURVE_W-1:0] level
);

    localparam int HALF = 1 << (ADDR_W - 1);

    logic [CURVE_W-1:0] tab [HALF];
    logic [ADDR_W-2:0]  fold_idx;

    for (genvar i = 0; i < HALF; i++) begin : g_ent
        assign tab[i] = CURVE_W'(curve_entry(64'(i), 64'(ADDR_W)));
    end

    // upper half of the offset range mirrors onto the stored lower half
    assign fold_idx = addr[ADDR_W-2:0] ^ {(ADDR_W-1){addr[ADDR_W-1]}};
    assign level    = tab[fold_idx];

endmodule

// File: rtl/fl2log_conv.sv
module fl2log_conv import fl2log_pkg::*; #(
    parameter int SEG_BITS     = 6,
    parameter int TBL_ADDR_W   = 10,
    parameter int EXTRA_STAGES = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [FP_W-1:0]          in_word,
    output logic                     out_valid,
    output logic                     out_err,
    output logic [EXP_W+MANT_W-1:0]  out_log
);

    localparam int OFF_W   = MANT_W - SEG_BITS;
    localparam int SLOPE_W = ACC_FRAC - SEG_BITS + 1;
    localparam int SCALE_W = ACC_FRAC - 2 * SEG_BITS;
    localparam int OUT_W   = EXP_W + MANT_W;
    localparam int LIN_W   = SLOPE_W + OFF_W;
    localparam int CORR_W  = SCALE_W + CURVE_W;
    localparam int SUM_W   = ACC_FRAC + 1;

    typedef struct packed {
        logic                valid;
        logic                err;
        logic [EXP_W-1:0]    ipart;
        logic [ACC_FRAC-1:0] base;
        logic [SLOPE_W-1:0]  slope;
        logic [SCALE_W-1:0]  scale;
        logic [OFF_W-1:0]    off;
        logic [CURVE_W-1:0]  level;
    } s1_t;

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [OUT_W-1:0] val;
    } res_t;

    // ---------------- stage 1: decode and table reads ----------------
    logic                cls_bad;
    logic [EXP_W-1:0]    cls_ipart;
    logic [SEG_BITS-1:0] cls_seg;
    logic [OFF_W-1:0]    cls_off;
    logic [ACC_FRAC-1:0] rom_base;
    logic [SLOPE_W-1:0]  rom_slope;
    logic [SCALE_W-1:0]  rom_scale;
    logic [CURVE_W-1:0]  rom_level;

    fl2log_classify #(.SEG_BITS(SEG_BITS), .OFF_W(OFF_W)) u_cls (
        .word  (in_word),
        .bad   (cls_bad),
        .ipart (cls_ipart),
        .seg   (cls_seg),
        .off   (cls_off)
    );

    fl2log_seg_rom #(.SEG_BITS(SEG_BITS), .SLOPE_W(SLOPE_W), .SCALE_W(SCALE_W)) u_seg (
        .seg   (cls_seg),
        .base  (rom_base),
        .slope (rom_slope),
        .scale (rom_scale)
    );

    fl2log_curve_rom #(.ADDR_W(TBL_ADDR_W)) u_curve (
        .addr  (cls_off[OFF_W-1 -: TBL_ADDR_W]),
        .level (rom_level)
    );

    s1_t s1_d, s1_q;

    always_comb begin
        s1_d.valid = in_valid;
        s1_d.err   = cls_bad;
        s1_d.ipart = cls_ipart;
        s1_d.base  = rom_base;
        s1_d.slope = rom_slope;
        s1_d.scale = rom_scale;
        s1_d.off   = cls_off;
        s1_d.level = rom_level;
    end

    // ---------------- stage 2: interpolate, correct, assemble ----------------
    logic [LIN_W-1:0]    lin_prod;
    logic [SLOPE_W-1:0]  lin;
    logic [CORR_W-1:0]   corr_prod;
    logic [SCALE_W-1:0]  corr;
    logic [SUM_W-1:0]    sum;
    logic [MANT_W-1:0]   frac;
    res_t                res_d, res_q;

    always_comb begin
        lin_prod  = LIN_W'(s1_q.slope) * LIN_W'(s1_q.off);
        lin       = SLOPE_W'(lin_prod >> OFF_W);
        corr_prod = CORR_W'(s1_q.scale) * CORR_W'(s1_q.level);
        corr      = SCALE_W'(corr_prod >> CURVE_W);
        sum       = SUM_W'(s1_q.base) + SUM_W'(lin) + SUM_W'(corr);
        frac      = MANT_W'(sum >> GUARD_W);
        res_d.valid = s1_q.valid;
        res_d.err   = s1_q.valid & s1_q.err;
        res_d.val   = s1_q.err ? '0 : {s1_q.ipart, frac};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= '0;
            res_q <= '0;
        end else begin
            s1_q  <= s1_d;
            res_q <= res_d;
        end
    end

    // ---------------- optional retiming delay ----------------
    res_t tail;

    if (EXTRA_STAGES == 0) begin : g_direct
        assign tail = res_q;
    end else begin : g_delay
        res_t dly_q [EXTRA_STAGES];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < EXTRA_STAGES; k++) dly_q[k] <= '0;
            end else begin
                dly_q[0] <= res_q;
                for (int k = 1; k < EXTRA_STAGES; k++) dly_q[k] <= dly_q[k-1];
            end
        end
        assign tail = dly_q[EXTRA_STAGES-1];
    end

    assign out_valid = tail.valid;
    assign out_err   = tail.err;
    assign out_log   = tail.val;

    // ---------------- assertions ----------------
    // R6: a sampled input word always enters the first stage
    p_stage_fill_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_q.valid);

    // R6: no word enters the first stage without input
    p_stage_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !s1_q.valid);

    // R1: fraction never carries into the integer field
    p_no_carry_r1: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && !s1_q.err) |-> (sum[ACC_FRAC] == 1'b0));

    // R2: correction never exceeds the segment's peak chord error
    p_corr_cap_r2: assert property (@(posedge clk) disable iff (rst)
        s1_q.valid |-> (corr <= s1_q.scale));

    // R5: flagged results carry a zero value
    p_err_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> (out_log == '0));

    // R1: accepted results have an integer part of a normal exponent
    p_int_range_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_err) |-> ($signed(out_log[OUT_W-1 -: EXP_W]) >= -126));

    // R7: the flag only appears on a valid result
    p_flag_qual_r7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_err);

endmodule

// File: tb/tb_fl2log_conv.sv
module tb_fl2log_conv;

    localparam int LAT   = 2;
    localparam int OUT_W = 31;
    localparam real LSB  = 1.0 / 8388608.0;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [31:0]      in_word = '0;
    logic             out_valid;
    logic             out_err;
    logic [OUT_W-1:0] out_log;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] q_word [$];
    string       q_tag  [$];
    logic [LAT-1:0] vhist;
    logic [31:0] mon_w;
    string       mon_tag;

    fl2log_conv dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_err   (out_err),
        .out_log   (out_log)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string act, input string expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %s expected %s", req, act, expv);
        end
    endtask

    // expected result judged from the input word alone
    task automatic check_result(input logic [31:0] w, input string tag);
        int  e;
        int  m;
        bit  rej;
        real refv, got, diff;
        logic [OUT_W-1:0] exact;
        e   = int'(w[30:23]);
        m   = int'(w[22:0]);
        rej = w[31] || (e == 0) || (e == 255);
        if (rej) begin
            chk(out_err === 1'b1 && out_log === '0, (tag == "R8") ? "R8/R5" : "R5",
                $sformatf("err=%0b log=%h", out_err, out_log), "err=1 log=0000000");
        end else begin
            chk(out_err === 1'b0, tag, $sformatf("err=%0b", out_err), "err=0");
            chk($signed(out_log[30:23]) == e - 127, "R1",
                $sformatf("int=%0d", $signed(out_log[30:23])), $sformatf("int=%0d", e - 127));
            refv = $itor(e - 127) + $ln(1.0 + $itor(m) * LSB) / $ln(2.0);
            got  = $itor($signed(out_log)) * LSB;
            diff = got - refv;
            if (diff < 0.0) diff = -diff;
            chk(diff <= 4.0 * LSB, tag,
                $sformatf("%.9f (word %h)", got, w), $sformatf("%.9f +-4 lsb", refv));
            if (m == 0) begin
                exact = {8'(e - 127), 23'd0};
                chk(out_log === exact, "R3", $sformatf("%h", out_log), $sformatf("%h", exact));
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) vhist <= '0;
        else     vhist <= {vhist[LAT-2:0], in_valid};
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(out_valid === vhist[LAT-1], "R6",
                $sformatf("valid=%0b", out_valid), $sformatf("valid=%0b", vhist[LAT-1]));
            if (out_valid === 1'b1) begin
                if (q_word.size() == 0) begin
                    chk(1'b0, "R6", "extra result", "no result");
                end else begin
                    mon_w   = q_word.pop_front();
                    mon_tag = q_tag.pop_front();
                    check_result(mon_w, mon_tag);
                end
            end
        end
    end

    task automatic push_vec(input logic [31:0] w, input string tag);
        in_word  = w;
        in_valid = 1'b1;
        q_word.push_back(w);
        q_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        int n;
        n = 0;
        in_valid = 1'b0;
        while (q_word.size() != 0 && n < 40) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        chk(q_word.size() == 0, "R6", $sformatf("%0d pending", q_word.size()), "0 pending");
    endtask

    function automatic logic [31:0] good_word(input int e, input int m);
        return {1'b0, 8'(e), 23'(m)};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(out_valid === 1'b0 && out_err === 1'b0 && out_log === '0, "R7",
                $sformatf("%0b %0b %h", out_valid, out_err, out_log), "0 0 0000000");
        end
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0 && out_err === 1'b0 && out_log === '0, "R7",
            $sformatf("%0b %0b %h", out_valid, out_err, out_log), "0 0 0000000");
    endtask

    task automatic t_powers();           // R1, R3
        int exps [6] = '{1, 100, 126, 127, 128, 254};
        foreach (exps[i]) push_vec(good_word(exps[i], 0), "R3");
        push_vec(good_word(254, 23'h7FFFFF), "R2");
        push_vec(good_word(1, 23'h7FFFFF), "R2");
        drain();
    endtask

    task automatic t_segments();         // R4
        int offs [4] = '{32'h08000, 32'h10000, 32'h18000, 32'h1FFFF};
        for (int s = 0; s < 64; s++) begin
            foreach (offs[j]) push_vec(good_word(1 + (s * 3) % 254, (s << 17) | offs[j]), "R4");
        end
        drain();
    endtask

    task automatic t_random();           // R2
        for (int i = 0; i < 300; i++) begin
            push_vec(good_word(1 + int'($urandom % 254), int'($urandom & 32'h7FFFFF)), "R2");
        end
        drain();
    endtask

    task automatic t_specials();         // R5
        logic [31:0] sp [8] = '{32'h00000000, 32'h80000000, 32'h00000001, 32'h007FFFFF,
                                32'h7F800000, 32'h7FC00000, 32'hBF800000, 32'hFF7FFFFF};
        foreach (sp[i]) push_vec(sp[i], "R5");
        drain();
    endtask

    task automatic t_mixed();            // R8
        logic [31:0] sp [5] = '{32'h00000000, 32'h00400000, 32'h7F800000, 32'hC0490FDB, 32'h7FFFFFFF};
        for (int i = 0; i < 40; i++) begin
            if (i % 2 == 1) push_vec(sp[i % 5], "R8");
            else push_vec(good_word(1 + int'($urandom % 254), int'($urandom & 32'h7FFFFF)), "R8");
        end
        drain();
    endtask

    task automatic t_gaps();             // R6
        for (int i = 0; i < 60; i++) begin
            push_vec(good_word(1 + int'($urandom % 254), int'($urandom & 32'h7FFFFF)), "R6");
            idle(int'($urandom % 3));
        end
        drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_powers();
        t_segments();
        t_random();
        t_specials();
        t_mixed();
        t_gaps();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule